// File: doc/BRIEF.md
# Regulator Start-up Sequencer

This block orders the power-up and power-down of a switching regulator. When the supply-good input rises, it runs a fixed initialization window whether or not enable is high. At the end of that window it captures a 4-bit configuration strap once. The captured strap selects the soft-start duration, one of two compensation settings and the response to output faults. The capture holds until the supply drops, so toggling enable never re-reads the strap.

Once enable is high and the initialization window has finished, the sequencer waits through a power-on delay. It then ramps a digital reference code from zero to full scale, one LSB per fixed interval, so that full scale arrives exactly at the selected soft-start time.

The driver enables obey a rule for pre-biased outputs:
- The high-side enable waits for the comparator to report that the reference has passed the feedback level.
- The low-side enable waits for the first high-side pulse.

After the ramp ends and regulation is reported, a fixed delay runs before power-good asserts. Dropping enable clears the drivers, the reference and power-good on the next clock. Losing supply-good also clears the captured configuration.

Top module: `reg_startup_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, every output is zero: ramp code, both driver enables, power-good, cfg_locked and all configuration fields.
- R2: cfg_locked rises INIT_T+1 rising edges after supply_ok first reads high, whatever the level of en. INIT_T is CLK_KHZ*INIT_US/1000 clock cycles.
- R3: The captured configuration splits strap_code as follows. Bits [1:0] are cfg_ss_sel, where 00, 01, 10 and 11 mean 1, 2, 4 and 8 times SS_BASE_US. Bit 2 is cfg_comp2, where 1 means compensation set 2. Bit 3 is cfg_hiccup, where 1 means hiccup and 0 means latch-off. When strap_open is high at capture, the fields become ss_sel=10, comp2=0 and hiccup=0.
- R4: While supply_ok stays high, the configuration outputs do not change, even when strap_code changes or en toggles.
- R5: After en rises in the idle phase, the power-on delay lasts PON_T cycles. ramp_code first reads 1 exactly PON_T+STEP+1 edges after en is first sampled high. STEP is the soft-start tick count divided by RAMP_MAX.
- R6: ramp_code rises by exactly one LSB every STEP cycles and never exceeds RAMP_MAX. It takes (RAMP_MAX-1)*STEP cycles to go from 1 to RAMP_MAX, for each of the four soft-start settings.
- R7: hs_en stays low during soft start until ref_gt_fb is sampled high. When ref_gt_fb is already high, hs_en rises PON_T+2 edges after en.
- R8: ls_en is low until hs_pulse has been sampled high while hs_en is high. It then rises on the next edge, and it is never high without hs_en.
- R9: Power-good stays low until vreg_ok is seen after the ramp has reached full scale. It then rises PG_T+1 edges later, where PG_T is CLK_KHZ*PG_US/1000.
- R10: One edge after en is sampled low, hs_en, ls_en and pgood are low and ramp_code is zero.
- R11: One edge after supply_ok is sampled low, all outputs are zero, including cfg_locked and the configuration fields.
- R12: Neither driver enable is high before the configuration is captured or during the power-on delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_KHZ kHz |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Bias supply above its good threshold |
| en | input | 1 | Converter enable |
| strap_code | input | 4 | Configuration strap value |
| strap_open | input | 1 | No strap detected; capture the defaults |
| ref_gt_fb | input | 1 | Comparator: reference is above the feedback voltage |
| hs_pulse | input | 1 | First high-side on-pulse issued by the PWM loop |
| vreg_ok | input | 1 | Output has reached regulation |
| ramp_code | output | RAMP_W | Soft-start reference code; RAMP_MAX is 0.8 V |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |
| pgood | output | 1 | Power-good |
| cfg_locked | output | 1 | Strap has been captured |
| cfg_ss_sel | output | 2 | Captured soft-start select |
| cfg_comp2 | output | 1 | Captured compensation select |
| cfg_hiccup | output | 1 | Captured fault response, 1 = hiccup |

## Verification
The bench builds the block with CLK_KHZ=100 and RAMP_MAX=25. The real microsecond settings then become 30 initialization cycles, 50 power-on cycles and 100 power-good cycles, with ramp steps of 4, 8, 16 and 32 cycles. With these values every soft-start setting, including the 8x one, can be timed edge by edge in one short run. The run also covers several supply cycles with different straps, a pre-biased start, and dropping enable and supply from the fully-on phase.

// File: rtl/reg_seq_pkg.sv
package reg_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_INIT, ST_IDLE, ST_PON, ST_RAMP, ST_SETTLE, ST_PGDLY, ST_ON
  } seq_state_e;

  // bit order equals the strap code bit order: [3] hiccup, [2] comp2, [1:0] ss
  typedef struct packed {
    logic       hiccup;
    logic       comp2;
    logic [1:0] ss_sel;
  } strap_cfg_t;

  localparam strap_cfg_t CFG_OPEN = '{hiccup: 1'b0, comp2: 1'b0, ss_sel: 2'b10};

  function automatic int unsigned ticks_of(input int unsigned khz, input int unsigned us);
    int unsigned t;
    t = (khz * us) / 1000;
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/reg_seq_timer.sv
module reg_seq_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             zero
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/reg_seq_strap.sv
module reg_seq_strap
  import reg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       capture,
  input  logic [3:0] code,
  input  logic       open,
  output strap_cfg_t cfg,
  output logic       locked
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cfg    <= '0;
      locked <= 1'b0;
    end else if (capture && !locked) begin
      cfg    <= open ? CFG_OPEN : strap_cfg_t'(code);
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/reg_seq_ramp.sv
module reg_seq_ramp
  import reg_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned SS_BASE_US = 1000,
  parameter int unsigned RAMP_MAX   = 200,
  parameter int unsigned RAMP_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic [1:0]        sel,
  output logic [RAMP_W-1:0] code,
  output logic              full
);
  localparam int unsigned STEP_MAX = ticks_of(CLK_KHZ, SS_BASE_US * 8) / RAMP_MAX;
  localparam int unsigned STEP_W   = (STEP_MAX < 2) ? 1 : $clog2(STEP_MAX);

  logic [STEP_W-1:0] reload [4];
  logic [STEP_W-1:0] icnt;

  for (genvar g = 0; g < 4; g++) begin : g_step
    localparam int unsigned STEP_G = ticks_of(CLK_KHZ, SS_BASE_US << g) / RAMP_MAX;
    assign reload[g] = STEP_W'((STEP_G == 0) ? 0 : STEP_G - 1);
  end

  assign full = (code == RAMP_W'(RAMP_MAX));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
      icnt <= reload[sel];
    end else if (run && !full) begin
      if (icnt == '0) begin
        code <= code + 1'b1;
        icnt <= reload[sel];
      end else begin
        icnt <= icnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/reg_startup_seq.sv
module reg_startup_seq
  import reg_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned INIT_US    = 300,
  parameter int unsigned PON_US     = 500,
  parameter int unsigned PG_US      = 1000,
  parameter int unsigned SS_BASE_US = 1000,
  parameter int unsigned RAMP_MAX   = 200,
  localparam int unsigned RAMP_W    = $clog2(RAMP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              en,
  input  logic [3:0]        strap_code,
  input  logic              strap_open,
  input  logic              ref_gt_fb,
  input  logic              hs_pulse,
  input  logic              vreg_ok,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              hs_en,
  output logic              ls_en,
  output logic              pgood,
  output logic              cfg_locked,
  output logic [1:0]        cfg_ss_sel,
  output logic              cfg_comp2,
  output logic              cfg_hiccup
);
  localparam int unsigned INIT_T = ticks_of(CLK_KHZ, INIT_US);
  localparam int unsigned PON_T  = ticks_of(CLK_KHZ, PON_US);
  localparam int unsigned PG_T   = ticks_of(CLK_KHZ, PG_US);
  localparam int unsigned T_MAX  = (INIT_T > PON_T) ? ((INIT_T > PG_T) ? INIT_T : PG_T)
                                                    : ((PON_T > PG_T) ? PON_T : PG_T);
  localparam int unsigned TMR_W  = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  seq_state_e        state_q, state_n;
  logic              tmr_zero, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  strap_cfg_t        cfg;
  logic              ramp_full, ramp_clr, ramp_run;
  logic              on_path, keep;

  // ---------------- phase sequencing ----------------
  always_comb begin
    state_n = state_q;
    if (!supply_ok) begin
      state_n = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_n = ST_INIT;
        ST_INIT:   if (tmr_zero) state_n = ST_IDLE;
        ST_IDLE:   if (en) state_n = ST_PON;
        ST_PON:    if (!en) state_n = ST_IDLE; else if (tmr_zero)  state_n = ST_RAMP;
        ST_RAMP:   if (!en) state_n = ST_IDLE; else if (ramp_full) state_n = ST_SETTLE;
        ST_SETTLE: if (!en) state_n = ST_IDLE; else if (vreg_ok)   state_n = ST_PGDLY;
        ST_PGDLY:  if (!en) state_n = ST_IDLE; else if (tmr_zero)  state_n = ST_ON;
        ST_ON:     if (!en) state_n = ST_IDLE;
        default:   state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_n;
  end

  // timer is loaded on every phase change with the length of the new phase
  assign tmr_load = (state_n != state_q);
  always_comb begin
    unique case (state_n)
      ST_INIT:  tmr_val = TMR_W'(INIT_T - 1);
      ST_PON:   tmr_val = TMR_W'(PON_T - 1);
      ST_PGDLY: tmr_val = TMR_W'(PG_T - 1);
      default:  tmr_val = '0;
    endcase
  end

  reg_seq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // ---------------- configuration capture ----------------
  reg_seq_strap u_strap (
    .clk     (clk),
    .rst     (rst),
    .clr     (!supply_ok),
    .capture (state_q == ST_INIT && tmr_zero),
    .code    (strap_code),
    .open    (strap_open),
    .cfg     (cfg),
    .locked  (cfg_locked)
  );

  assign cfg_ss_sel = cfg.ss_sel;
  assign cfg_comp2  = cfg.comp2;
  assign cfg_hiccup = cfg.hiccup;

  // ---------------- reference ramp ----------------
  assign on_path  = (state_q == ST_RAMP) || (state_q == ST_SETTLE) ||
                    (state_q == ST_PGDLY) || (state_q == ST_ON);
  assign keep     = supply_ok && en;
  assign ramp_clr = !(keep && on_path);
  assign ramp_run = (state_q == ST_RAMP);

  reg_seq_ramp #(
    .CLK_KHZ    (CLK_KHZ),
    .SS_BASE_US (SS_BASE_US),
    .RAMP_MAX   (RAMP_MAX),
    .RAMP_W     (RAMP_W)
  ) u_ramp (
    .clk  (clk),
    .rst  (rst),
    .clr  (ramp_clr),
    .run  (ramp_run),
    .sel  (cfg.ss_sel),
    .code (ramp_code),
    .full (ramp_full)
  );

  // ---------------- drivers and power-good ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_en <= 1'b0;
      ls_en <= 1'b0;
      pgood <= 1'b0;
    end else begin
      hs_en <= keep && on_path && (hs_en || ref_gt_fb);
      ls_en <= keep && on_path && hs_en && (ls_en || hs_pulse);
      pgood <= (state_n == ST_ON);
    end
  end
endmodule

// File: rtl/reg_seq_chk.sv
module reg_seq_chk #(
  parameter int unsigned RAMP_MAX = 200,
  parameter int unsigned RAMP_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              supply_ok,
  input logic              en,
  input logic              ref_gt_fb,
  input logic [RAMP_W-1:0] ramp_code,
  input logic              hs_en,
  input logic              ls_en,
  input logic              pgood,
  input logic              cfg_locked,
  input logic [1:0]        cfg_ss_sel,
  input logic              cfg_comp2,
  input logic              cfg_hiccup
);
  p_ramp_step_r6: assert property (@(posedge clk) disable iff (rst)
    (ramp_code != $past(ramp_code)) |-> (ramp_code == $past(ramp_code) + 1'b1 || ramp_code == '0));

  p_ramp_max_r6: assert property (@(posedge clk) disable iff (rst)
    ramp_code <= RAMP_W'(RAMP_MAX));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_locked && supply_ok) |=> $stable({cfg_hiccup, cfg_comp2, cfg_ss_sel}));

  p_hs_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> $past(ref_gt_fb));

  p_ls_gate_r8: assert property (@(posedge clk) disable iff (rst)
    ls_en |-> hs_en);

  p_pg_full_r9: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (ramp_code == RAMP_W'(RAMP_MAX)));

  p_en_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_en && !ls_en && !pgood && ramp_code == '0));

  p_supply_off_r11: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!cfg_locked && !hs_en && !pgood && ramp_code == '0));

  p_no_drive_r12: assert property (@(posedge clk) disable iff (rst)
    !cfg_locked |-> (!hs_en && !ls_en));
endmodule

bind reg_startup_seq reg_seq_chk #(.RAMP_MAX(RAMP_MAX), .RAMP_W(RAMP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .supply_ok  (supply_ok),
  .en         (en),
  .ref_gt_fb  (ref_gt_fb),
  .ramp_code  (ramp_code),
  .hs_en      (hs_en),
  .ls_en      (ls_en),
  .pgood      (pgood),
  .cfg_locked (cfg_locked),
  .cfg_ss_sel (cfg_ss_sel),
  .cfg_comp2  (cfg_comp2),
  .cfg_hiccup (cfg_hiccup)
);

// File: tb/reg_startup_seq_tb.sv
`timescale 1ns/1ps
module reg_startup_seq_tb;
  localparam int unsigned KHZ   = 100;
  localparam int unsigned RMAX  = 25;
  localparam int unsigned RW    = $clog2(RMAX + 1);
  localparam int          INIT_T = 30;
  localparam int          PON_T  = 50;
  localparam int          PG_T   = 100;
  localparam int          PB_CODE = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0, en = 1'b0, strap_open = 1'b0;
  logic ref_gt_fb = 1'b0, hs_pulse = 1'b0, vreg_ok = 1'b0;
  logic [3:0] strap_code = 4'h0;
  logic [RW-1:0] ramp_code;
  logic hs_en, ls_en, pgood, cfg_locked, cfg_comp2, cfg_hiccup;
  logic [1:0] cfg_ss_sel;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reg_startup_seq #(
    .CLK_KHZ(KHZ), .INIT_US(300), .PON_US(500), .PG_US(1000),
    .SS_BASE_US(1000), .RAMP_MAX(RMAX)
  ) u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .en(en),
    .strap_code(strap_code), .strap_open(strap_open),
    .ref_gt_fb(ref_gt_fb), .hs_pulse(hs_pulse), .vreg_ok(vreg_ok),
    .ramp_code(ramp_code), .hs_en(hs_en), .ls_en(ls_en), .pgood(pgood),
    .cfg_locked(cfg_locked), .cfg_ss_sel(cfg_ss_sel),
    .cfg_comp2(cfg_comp2), .cfg_hiccup(cfg_hiccup)
  );

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cfg_now();
    return {cfg_hiccup, cfg_comp2, cfg_ss_sel};
  endfunction

  // R1
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 outputs in reset", {ramp_code, hs_en, ls_en, pgood, cfg_locked, cfg_now()}, 0);
    rst = 1'b0;
    tick();
    chk("R1 outputs after reset", {ramp_code, hs_en, ls_en, pgood, cfg_locked, cfg_now()}, 0);
  endtask

  // R2, R3, R11, R12: drop supply, present a strap, raise supply, time the capture
  task automatic t_supply_cycle(input logic [3:0] code, input logic open,
                                input logic en_init, input logic [3:0] exp_cfg);
    int c0;
    supply_ok = 1'b0; en = 1'b0; ref_gt_fb = 1'b0; hs_pulse = 1'b0; vreg_ok = 1'b0;
    tick();
    chk("R11 cfg cleared without supply", {cfg_locked, cfg_now()}, 0);
    strap_code = code; strap_open = open; en = en_init;
    tick();
    supply_ok = 1'b1;
    c0 = cyc;
    while (!cfg_locked && cyc - c0 < 1000) begin
      tick();
      if (!cfg_locked) chk("R12 no drive before capture", {hs_en, ls_en}, 0);
    end
    chk("R2 init length", cyc - c0, INIT_T + 1);
    chk("R3 captured fields", cfg_now(), exp_cfg);
  endtask

  // R5 .. R9: one start-up from idle with a given soft-start select
  task automatic t_power_up(input int sel, input bit prebias);
    int step, c0, hs_at, c_first, c_pg;
    step = (4 << sel);
    hs_at = 0;
    ref_gt_fb = !prebias;
    en = 1'b1;
    c0 = cyc;
    while (ramp_code == 0 && cyc - c0 < 5000) begin
      tick();
      if (hs_en && hs_at == 0) hs_at = cyc - c0;
      if (cyc - c0 <= PON_T) chk("R12 drivers off in power-on delay", {hs_en, ls_en}, 0);
    end
    c_first = cyc;
    chk("R5 first ramp step latency", cyc - c0, PON_T + step + 1);
    chk("R5 first ramp code", ramp_code, 1);
    if (!prebias) begin
      chk("R7 hs_en timing without pre-bias", hs_at, PON_T + 2);
    end else begin
      while (ramp_code != PB_CODE && cyc - c0 < 5000) tick();
      chk("R7 hs_en held on pre-bias", hs_en, 0);
      ref_gt_fb = 1'b1;
      tick();
      chk("R7 hs_en after reference passes", hs_en, 1);
    end
    chk("R8 ls_en before first hs pulse", ls_en, 0);
    hs_pulse = 1'b1;
    tick();
    chk("R8 ls_en after first hs pulse", ls_en, 1);
    while (ramp_code != RMAX && cyc - c0 < 5000) tick();
    chk("R6 ramp duration", cyc - c_first, (RMAX - 1) * step);
    repeat (3) tick();
    chk("R6 ramp holds full scale", ramp_code, RMAX);
    chk("R9 no pgood before regulation", pgood, 0);
    vreg_ok = 1'b1;
    c_pg = cyc;
    while (!pgood && cyc - c_pg < 5000) tick();
    chk("R9 pgood delay", cyc - c_pg, PG_T + 1);
  endtask

  // R10 and R4
  task automatic t_disable_and_retoggle();
    logic [3:0] held;
    held = cfg_now();
    en = 1'b0;
    tick();
    chk("R10 all off after en low", {hs_en, ls_en, pgood, ramp_code}, 0);
    vreg_ok = 1'b0; hs_pulse = 1'b0; ref_gt_fb = 1'b0;
    strap_code = ~strap_code;
    strap_open = ~strap_open;
    en = 1'b1;
    repeat (3) tick();
    en = 1'b0;
    repeat (2) tick();
    chk("R4 cfg unchanged by en toggle", {cfg_locked, cfg_now()}, {1'b1, held});
  endtask

  // R11 from the fully-on phase
  task automatic t_supply_loss();
    supply_ok = 1'b0;
    tick();
    chk("R11 all clear after supply loss",
        {ramp_code, hs_en, ls_en, pgood, cfg_locked, cfg_now()}, 0);
    en = 1'b0; vreg_ok = 1'b0; hs_pulse = 1'b0; ref_gt_fb = 1'b0;
  endtask

  initial begin
    t_reset();
    t_supply_cycle(4'b0000, 1'b0, 1'b0, 4'b0000);
    t_power_up(0, 1'b0);
    t_disable_and_retoggle();
    t_power_up(0, 1'b1);
    t_disable_and_retoggle();
    t_supply_cycle(4'b1101, 1'b0, 1'b0, 4'b1101);
    t_power_up(1, 1'b0);
    t_supply_loss();
    t_supply_cycle(4'b1111, 1'b1, 1'b1, 4'b0010);
    t_supply_loss();
    t_supply_cycle(4'b0110, 1'b0, 1'b0, 4'b0110);
    t_power_up(2, 1'b1);
    t_supply_cycle(4'b1011, 1'b0, 1'b0, 4'b1011);
    t_power_up(3, 1'b0);
    t_disable_and_retoggle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule